// File: doc/BRIEF.md
# Spill Handshake Status Register

This block is the meeting point between a hardware capture engine and the acquisition software across accelerator spill cycles. Two asynchronous level inputs say whether the beam is in a burst or in the gap between bursts. They are synchronised and decoded into a two-bit phase code that software can read. The capture engine collects detector data while a burst is in progress, and software drains it during the gap that follows.

When a burst ends, the block raises a ready flag. Software starts reading once it sees that flag, and when it is done it clears the flag by writing a one to it. If a new burst starts while the ready flag is still set, software did not finish in time. The block then raises a sticky timeout flag, which stays set until software clears it explicitly. The register is a single word: reads are continuous through `status_o`, and writes are single-cycle strobes.

Top module: `spill_status_reg`

## Requirements
- R1: Bits 1:0 of `status_o` hold the phase code: 2'b10 while the synchronised burst input is high (burst wins over interburst), 2'b11 while only interburst is high, and 2'b00 when neither is high. A level change on an input reaches the code after exactly two rising clock edges.
- R2: The code 2'b01 never appears on bits 1:0.
- R3: Bit 2 (ready) goes high on the third rising edge after the burst input falls.
- R4: Once set, ready stays high until a write with bit 2 of `wr_data_i` at 1 clears it on the following edge.
- R5: Bit 3 (timeout) goes high on the third rising edge after the burst input rises, provided ready is high at that point.
- R6: Timeout is sticky. It stays high after ready has been cleared and is cleared only by a write with bit 3 of `wr_data_i` at 1.
- R7: Write data bits 1:0, bits above 3, and zero bits in positions 2 and 3 have no effect on `status_o`.
- R8: When a set event and a clearing write for the same flag fall on the same edge, the flag ends up set.
- R9: While `rst_ni` is low, `status_o` reads all zeros.
- R10: Bits of `status_o` above bit 3 always read zero.
- R11: A burst start while ready is low leaves timeout unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| burst_i | input | 1 | Asynchronous burst-in-progress level |
| interburst_i | input | 1 | Asynchronous interburst-gap level |
| wr_en_i | input | 1 | Single-cycle write strobe |
| wr_data_i | input | DATA_W | Write data; bits 2 and 3 are write-one-to-clear |
| status_o | output | DATA_W | Phase code, ready flag and timeout flag |

## Verification
The bench builds the block with its default values: an 8-bit register and two synchroniser stages. With a byte-wide word, every write value can be swept against a fully armed register, covering all combinations of the clear bits together with the ignored low and upper bits. With two synchroniser stages, the exact-edge latency of the phase code, the ready flag and the timeout flag can each be checked cycle by cycle. All sixteen ordered transitions between the four input level pairs are also run to confirm the phase decode and its burst priority.

// File: rtl/spill_pkg.sv
package spill_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_BURST = 2'b10,
    PH_GAP   = 2'b11
  } phase_e;
  localparam int unsigned RDY_BIT = 2;
  localparam int unsigned TMO_BIT = 3;
endpackage

// File: rtl/spill_sync.sv
module spill_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) chain_q[0] <= '0;
    else         chain_q[0] <= d_i;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= chain_q[s-1];
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/spill_phase.sv
module spill_phase
  import spill_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   burst_s_i,
  input  logic   gap_s_i,
  output phase_e phase_o,
  output logic   start_o,
  output logic   end_o
);
  logic burst_d_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) burst_d_q <= 1'b0;
    else         burst_d_q <= burst_s_i;

  assign start_o = burst_s_i & ~burst_d_q;
  assign end_o   = ~burst_s_i & burst_d_q;

  always_comb begin
    if (burst_s_i)    phase_o = PH_BURST;
    else if (gap_s_i) phase_o = PH_GAP;
    else              phase_o = PH_IDLE;
  end
endmodule

// File: rtl/spill_flags.sv
module spill_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic end_i,
  input  logic clr_rdy_i,
  input  logic clr_tmo_i,
  output logic rdy_o,
  output logic tmo_o
);
  logic rdy_q, tmo_q;

  // set terms are OR-ed after the clear so a coincident set wins
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      rdy_q <= end_i | (rdy_q & ~clr_rdy_i);
      tmo_q <= (start_i & rdy_q) | (tmo_q & ~clr_tmo_i);
    end

  assign rdy_o = rdy_q;
  assign tmo_o = tmo_q;
endmodule

// File: rtl/spill_status_reg.sv
module spill_status_reg
  import spill_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burst_i,
  input  logic              interburst_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] status_o
);
  localparam int unsigned FLAG_TOP = TMO_BIT + 1;

  logic [1:0] lvl_s;
  phase_e     phase;
  logic       start, fin, rdy, tmo;

  spill_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({interburst_i, burst_i}),
    .q_o   (lvl_s)
  );

  spill_phase u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .burst_s_i(lvl_s[0]),
    .gap_s_i  (lvl_s[1]),
    .phase_o  (phase),
    .start_o  (start),
    .end_o    (fin)
  );

  spill_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .end_i    (fin),
    .clr_rdy_i(wr_en_i & wr_data_i[RDY_BIT]),
    .clr_tmo_i(wr_en_i & wr_data_i[TMO_BIT]),
    .rdy_o    (rdy),
    .tmo_o    (tmo)
  );

  logic unused_wr;
  assign unused_wr = ^{wr_data_i[DATA_W-1:FLAG_TOP], wr_data_i[1:0]};

  always_comb begin
    status_o          = '0;
    status_o[1:0]     = phase;
    status_o[RDY_BIT] = rdy;
    status_o[TMO_BIT] = tmo;
  end
endmodule

// File: rtl/spill_status_reg_chk.sv
module spill_status_reg_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] status_o
);
  a_r2_no_code_01: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1:0] != 2'b01);

  a_r10_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[DATA_W-1:4] == '0);

  a_r4_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] && !(wr_en_i && wr_data_i[2])) |=> status_o[2]);

  a_r6_timeout_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !(wr_en_i && wr_data_i[3])) |=> status_o[3]);

  a_r5_timeout_needs_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> $past(status_o[2]));

  a_r3_ready_after_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> ($past(status_o[1:0]) != 2'b10));
endmodule

bind spill_status_reg spill_status_reg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .status_o (status_o)
);

// File: tb/spill_status_reg_tb.sv
`timescale 1ns/1ps
module spill_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       burst = 1'b0, gap = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  spill_status_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .burst_i(burst), .interburst_i(gap),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .status_o(status)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    step(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic logic [1:0] exp_ph(input logic b, input logic g);
    return b ? 2'b10 : (g ? 2'b11 : 2'b00);
  endfunction

  task automatic pulse();
    burst = 1'b1; step(4);
    burst = 1'b0; step(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    burst = 1'b1;
    step(2);
    check("R9 reset", status, 8'h00);
    burst = 1'b0; step(3);
    rst_n = 1'b1; step(1);
    check("R9 after release", status, 8'h00);

    // R1 latency
    burst = 1'b1; step(1);
    check("R1 one edge", {6'b0, status[1:0]}, 8'h00);
    step(1);
    check("R1 two edges", {6'b0, status[1:0]}, 8'h02);
    burst = 1'b0; step(4);

    // R1/R2 all ordered transitions between input level pairs
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        burst = a[0]; gap = a[1]; step(3);
        check("R1 phase from", {6'b0, status[1:0]}, {6'b0, exp_ph(a[0], a[1])});
        burst = b[0]; gap = b[1]; step(3);
        check("R1 phase to", {6'b0, status[1:0]}, {6'b0, exp_ph(b[0], b[1])});
        check("R2 no 01", {7'b0, status[1:0] == 2'b01}, 8'h00);
      end
    burst = 1'b0; gap = 1'b0; step(4);
    wr(8'h0C);
    check("R4 clear both", status, 8'h00);

    // R11 start without ready
    burst = 1'b1; step(4);
    check("R11 no timeout", status, 8'h02);
    // R3 ready latency
    burst = 1'b0; step(2);
    check("R3 not before third edge", status, 8'h00);
    step(1);
    check("R3 ready set", status, 8'h04);
    step(10);
    check("R4 ready holds", status, 8'h04);
    // R5 timeout latency
    burst = 1'b1; step(2);
    check("R5 not before third edge", status, 8'h06);
    step(1);
    check("R5 timeout set", status, 8'h0E);
    burst = 1'b0; step(4);
    check("R3 ready again", status, 8'h0C);
    wr(8'h04);
    check("R6 timeout sticky", status, 8'h08);
    step(5);
    check("R6 timeout still set", status, 8'h08);
    wr(8'h08);
    check("R6 timeout cleared", status, 8'h00);

    // R8 set wins on ready
    burst = 1'b1; step(4);
    burst = 1'b0; step(2);
    wr(8'h04);
    check("R8 ready set wins", status, 8'h04);
    // R8 set wins on timeout
    burst = 1'b1; step(2);
    wr(8'h08);
    check("R8 timeout set wins", status, 8'h0E);
    burst = 1'b0; step(4);

    // R7/R10 write sweep with the register fully armed, in interburst
    gap = 1'b1;
    for (int v = 0; v < 256; v++) begin
      pulse(); pulse();
      check("R7 armed", status, 8'h0F);
      wr(8'(v));
      check("R7 R10 write effect", status,
            8'h03 | (v[2] ? 8'h00 : 8'h04) | (v[3] ? 8'h00 : 8'h08));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule